// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI and LO Result Registers

This block performs 32-bit integer multiply and divide, one bit per clock. It holds two 32-bit result registers, HI and LO. A multiply leaves the 64-bit product split across the pair: the upper half goes to HI and the lower half to LO. A divide puts the quotient in LO and the remainder in HI. Both registers can also be loaded directly from an operand, and read back through a one-cycle read-result port.

An operation is requested by pulsing `start` with a 6-bit function code and two operands. Multiply and divide raise `busy` for exactly 32 cycles. While `busy` is high, the unit ignores write and arithmetic requests. A read request made while busy is held and is answered once the running operation has committed. Signed forms treat operands as two's complement. No form raises an exception. A division by zero runs to completion and leaves HI and LO as they were.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `hi_q` and `lo_q` are zero, and `busy` and `rd_valid` are low.
- R2: Function codes are 0x18 signed multiply, 0x19 unsigned multiply, 0x1A signed divide, 0x1B unsigned divide, 0x10 read HI, 0x11 write HI, 0x12 read LO and 0x13 write LO. A request with any other code changes no output.
- R3: Unsigned multiply leaves the 64-bit product of `opa` and `opb` with bits 63..32 in HI and bits 31..0 in LO.
- R4: Signed multiply leaves the 64-bit two's-complement product of the signed operands, split the same way as in R3.
- R5: Unsigned divide of `opa` by nonzero `opb` leaves the quotient in LO and the remainder in HI.
- R6: Signed divide truncates the quotient toward zero and gives the remainder the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF yields quotient 0x80000000 and remainder 0.
- R7: An accepted multiply or divide holds `busy` high for exactly 32 cycles. The new HI and LO are visible in the first cycle `busy` is low.
- R8: A divide with `opb` equal to zero also finishes after 32 busy cycles, and HI and LO keep their prior values.
- R9: When idle, write HI (0x11) or write LO (0x13) loads `opa` into that register, visible in the cycle after the request.
- R10: While `busy` is high, write requests and new multiply or divide requests have no effect on HI, LO or the busy period.
- R11: When idle, read HI (0x10) or read LO (0x12) raises `rd_valid` for one cycle, in the cycle after the request, with `rd_data` equal to that register.
- R12: A read request made while busy is held. It is answered with `rd_valid` one cycle after `busy` falls, carrying the register value just committed. `rd_valid` never rises in a cycle that follows a busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one cycle per request |
| func | input | 6 | Function code of the request |
| opa | input | 32 | First operand: multiplicand, dividend or write data |
| opb | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | Multiply or divide in progress |
| hi_q | output | 32 | Current HI register |
| lo_q | output | 32 | Current LO register |
| rd_valid | output | 1 | One-cycle pulse marking a read result |
| rd_data | output | 32 | Read result for read HI or read LO |

## Verification
The hardest situation to reach is a read request that arrives during a running operation. The reply must come after the commit, not before it, and must carry the new value. The bench starts a signed multiply, issues a read of LO in the very next cycle, and counts cycles until `rd_valid` appears. It then checks that the reply is the freshly committed product and not the stale register. A second scenario piles a write and a second multiply into the busy window of a divide, and checks that neither one disturbs the result or stretches the busy period.

// File: rtl/md_pkg.sv
package md_pkg;
  localparam logic [5:0] FN_RD_HI  = 6'h10;
  localparam logic [5:0] FN_WR_HI  = 6'h11;
  localparam logic [5:0] FN_RD_LO  = 6'h12;
  localparam logic [5:0] FN_WR_LO  = 6'h13;
  localparam logic [5:0] FN_MUL_S  = 6'h18;
  localparam logic [5:0] FN_MUL_U  = 6'h19;
  localparam logic [5:0] FN_DIV_S  = 6'h1A;
  localparam logic [5:0] FN_DIV_U  = 6'h1B;

  function automatic logic fn_is_arith(input logic [5:0] f);
    return (f == FN_MUL_S) || (f == FN_MUL_U) || (f == FN_DIV_S) || (f == FN_DIV_U);
  endfunction

  function automatic logic fn_is_div(input logic [5:0] f);
    return (f == FN_DIV_S) || (f == FN_DIV_U);
  endfunction

  function automatic logic fn_is_signed(input logic [5:0] f);
    return (f == FN_MUL_S) || (f == FN_DIV_S);
  endfunction

  function automatic logic fn_is_read(input logic [5:0] f);
    return (f == FN_RD_HI) || (f == FN_RD_LO);
  endfunction
endpackage

// File: rtl/md_prep.sv
module md_prep #(
  parameter int W = 32
) (
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         a_neg,
  output logic         b_neg
);
  always_comb begin
    a_neg = sgn & a[W-1];
    b_neg = sgn & b[W-1];
    a_mag = a_neg ? (~a + W'(1)) : a;
    b_mag = b_neg ? (~b + W'(1)) : b;
  end
endmodule

// File: rtl/md_engine.sv
module md_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         is_div,
  input  logic [W-1:0] a_mag,
  input  logic [W-1:0] b_mag,
  output logic         last,
  output logic [W-1:0] nxt_up,
  output logic [W-1:0] nxt_lo
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  up_q, low_q, opnd_q;
  logic [CW-1:0] cnt_q;
  logic          active_q, div_q;

  logic [W:0]    mul_sum;
  logic [W:0]    div_sh, div_diff;

  always_comb begin
    mul_sum  = {1'b0, up_q} + (low_q[0] ? {1'b0, opnd_q} : '0);
    div_sh   = {up_q, low_q[W-1]};
    div_diff = div_sh - {1'b0, opnd_q};
    if (div_q) begin
      if (!div_diff[W]) begin
        nxt_up = div_diff[W-1:0];
        nxt_lo = {low_q[W-2:0], 1'b1};
      end else begin
        nxt_up = div_sh[W-1:0];
        nxt_lo = {low_q[W-2:0], 1'b0};
      end
    end else begin
      nxt_up = mul_sum[W:1];
      nxt_lo = {mul_sum[0], low_q[W-1:1]};
    end
    last = active_q && (cnt_q == CW'(W-1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q     <= '0;
      low_q    <= '0;
      opnd_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      div_q    <= 1'b0;
    end else if (load) begin
      up_q     <= '0;
      low_q    <= is_div ? a_mag : b_mag;
      opnd_q   <= is_div ? b_mag : a_mag;
      cnt_q    <= '0;
      active_q <= 1'b1;
      div_q    <= is_div;
    end else if (active_q) begin
      up_q  <= nxt_up;
      low_q <= nxt_lo;
      cnt_q <= cnt_q + CW'(1);
      if (last) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/md_fix.sv
module md_fix #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic [W-1:0] raw_up,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = {raw_up, raw_lo};
    if (neg_q) prod = ~prod + (2*W)'(1);
    if (is_div) begin
      res_lo = neg_q ? (~raw_lo + W'(1)) : raw_lo;
      res_hi = neg_r ? (~raw_up + W'(1)) : raw_up;
    end else begin
      res_lo = prod[W-1:0];
      res_hi = prod[2*W-1:W];
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [5:0]   func,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  import md_pkg::*;

  logic [W-1:0] hi_r, lo_r, rd_data_r;
  logic         busy_r, dz_r, negq_r, negr_r, div_r;
  logic         pend_r, pend_hi_r, rd_valid_r;

  logic         accept, load;
  logic [W-1:0] a_mag, b_mag;
  logic         a_neg, b_neg;
  logic         eng_last;
  logic [W-1:0] eng_up, eng_lo, res_hi, res_lo;

  assign accept = start && !busy_r && !pend_r;
  assign load   = accept && fn_is_arith(func);

  md_prep #(.W(W)) u_prep (
    .sgn   (fn_is_signed(func)),
    .a     (opa),
    .b     (opb),
    .a_mag (a_mag),
    .b_mag (b_mag),
    .a_neg (a_neg),
    .b_neg (b_neg)
  );

  md_engine #(.W(W)) u_eng (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .is_div (fn_is_div(func)),
    .a_mag  (a_mag),
    .b_mag  (b_mag),
    .last   (eng_last),
    .nxt_up (eng_up),
    .nxt_lo (eng_lo)
  );

  md_fix #(.W(W)) u_fix (
    .is_div (div_r),
    .neg_q  (negq_r),
    .neg_r  (negr_r),
    .raw_up (eng_up),
    .raw_lo (eng_lo),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_r       <= '0;
      lo_r       <= '0;
      busy_r     <= 1'b0;
      dz_r       <= 1'b0;
      negq_r     <= 1'b0;
      negr_r     <= 1'b0;
      div_r      <= 1'b0;
      pend_r     <= 1'b0;
      pend_hi_r  <= 1'b0;
      rd_valid_r <= 1'b0;
      rd_data_r  <= '0;
    end else begin
      rd_valid_r <= 1'b0;
      if (load) begin
        busy_r <= 1'b1;
        div_r  <= fn_is_div(func);
        dz_r   <= fn_is_div(func) && (opb == '0);
        negq_r <= a_neg ^ b_neg;
        negr_r <= fn_is_div(func) && a_neg;
      end
      if (eng_last) begin
        busy_r <= 1'b0;
        if (!dz_r) begin
          hi_r <= res_hi;
          lo_r <= res_lo;
        end
      end
      if (accept && func == FN_WR_HI) hi_r <= opa;
      if (accept && func == FN_WR_LO) lo_r <= opa;
      if (start && busy_r && fn_is_read(func)) begin
        pend_r    <= 1'b1;
        pend_hi_r <= (func == FN_RD_HI);
      end
      if (accept && fn_is_read(func)) begin
        rd_valid_r <= 1'b1;
        rd_data_r  <= (func == FN_RD_HI) ? hi_r : lo_r;
      end
      if (pend_r && !busy_r) begin
        pend_r     <= 1'b0;
        rd_valid_r <= 1'b1;
        rd_data_r  <= pend_hi_r ? hi_r : lo_r;
      end
    end
  end

  assign busy     = busy_r;
  assign hi_q     = hi_r;
  assign lo_q     = lo_r;
  assign rd_valid = rd_valid_r;
  assign rd_data  = rd_data_r;
endmodule

// File: rtl/md_check.sv
module md_check #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [5:0]   func,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         busy,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q,
  input logic         rd_valid,
  input logic         held
);
  import md_pkg::*;

  logic [7:0]   busy_cnt;
  logic [5:0]   cap_f;
  logic [W-1:0] cap_a, cap_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      cap_f    <= '0;
      cap_a    <= '0;
      cap_b    <= '0;
    end else begin
      busy_cnt <= busy ? busy_cnt + 8'd1 : 8'd0;
      if (start && !busy && !held && fn_is_arith(func)) begin
        cap_f <= func;
        cap_a <= opa;
        cap_b <= opb;
      end
    end
  end

  // R7
  a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_cnt == 8'(W));

  // R3
  a_r3_multu_prod: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && cap_f == FN_MUL_U) |->
      {hi_q, lo_q} == ({{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b}));

  // R8
  a_r8_dz_keep: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && fn_is_div(cap_f) && cap_b == '0) |-> ($stable(hi_q) && $stable(lo_q)));

  // R9
  a_r9_write_hi: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !held && func == FN_WR_HI) |=> hi_q == $past(opa));

  // R10
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

  // R12
  a_r12_no_read_busy: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(busy));
endmodule

bind muldiv_hilo md_check #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .func     (func),
  .opa      (opa),
  .opb      (opb),
  .busy     (busy),
  .hi_q     (hi_q),
  .lo_q     (lo_q),
  .rd_valid (rd_valid),
  .held     (pend_r)
);

// File: tb/sim_muldiv_hilo.sv
module sim_muldiv_hilo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  func = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, rd_valid;
  logic [31:0] hi_q, lo_q, rd_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  muldiv_hilo u0 (
    .clk(clk), .rst(rst), .start(start), .func(func), .opa(opa), .opb(opb),
    .busy(busy), .hi_q(hi_q), .lo_q(lo_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] emul(input logic sg, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] xa, xb;
    xa = sg ? {{32{a[31]}}, a} : {32'b0, a};
    xb = sg ? {{32{b[31]}}, b} : {32'b0, b};
    return xa * xb;
  endfunction

  function automatic logic [63:0] ediv(input logic sg, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    if (sg) begin
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      q = sa / sb;
      r = sa % sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; func = f; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_arith(input string tag, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] e;
    int n;
    if (f == 6'h18 || f == 6'h19) e = emul(f == 6'h18, a, b);
    else e = ediv(f == 6'h1A, a, b);
    issue(f, a, b);
    wait_idle(n);
    chk({tag, " R7 busy cycles"}, 32'(n), 32'd32);
    chk({tag, " hi"}, hi_q, e[63:32]);
    chk({tag, " lo"}, lo_q, e[31:0]);
  endtask

  task automatic t_reset;
    chk("R1 hi", hi_q, 32'h0);
    chk("R1 lo", lo_q, 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 rd_valid", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_write;
    issue(6'h11, 32'h1234_5678, 32'h0);
    chk("R9 write hi", hi_q, 32'h1234_5678);
    issue(6'h13, 32'h9ABC_DEF0, 32'h0);
    chk("R9 write lo", lo_q, 32'h9ABC_DEF0);
    chk("R9 hi kept", hi_q, 32'h1234_5678);
  endtask

  task automatic t_read_idle;
    issue(6'h10, 32'h0, 32'h0);
    chk("R11 valid hi", 32'(rd_valid), 32'h1);
    chk("R11 data hi", rd_data, hi_q);
    @(negedge clk);
    chk("R11 pulse", 32'(rd_valid), 32'h0);
    issue(6'h12, 32'h0, 32'h0);
    chk("R11 valid lo", 32'(rd_valid), 32'h1);
    chk("R11 data lo", rd_data, lo_q);
  endtask

  task automatic t_unknown;
    logic [31:0] h, l;
    h = hi_q; l = lo_q;
    issue(6'h20, 32'hFFFF_FFFF, 32'h5);
    chk("R2 busy", 32'(busy), 32'h0);
    chk("R2 rd_valid", 32'(rd_valid), 32'h0);
    chk("R2 hi", hi_q, h);
    chk("R2 lo", lo_q, l);
  endtask

  task automatic t_div_zero;
    int n;
    issue(6'h11, 32'hAAAA_5555, 32'h0);
    issue(6'h13, 32'h0F0F_F0F0, 32'h0);
    issue(6'h1B, 32'd100, 32'd0);
    wait_idle(n);
    chk("R8 unsigned cycles", 32'(n), 32'd32);
    chk("R8 unsigned hi", hi_q, 32'hAAAA_5555);
    chk("R8 unsigned lo", lo_q, 32'h0F0F_F0F0);
    issue(6'h1A, 32'hFFFF_FFF9, 32'd0);
    wait_idle(n);
    chk("R8 signed cycles", 32'(n), 32'd32);
    chk("R8 signed hi", hi_q, 32'hAAAA_5555);
    chk("R8 signed lo", lo_q, 32'h0F0F_F0F0);
  endtask

  task automatic t_ignore_busy;
    int n;
    issue(6'h1B, 32'd100, 32'd7);
    start = 1'b1; func = 6'h11; opa = 32'hDEAD_BEEF;
    @(negedge clk);
    func = 6'h13;
    @(negedge clk);
    func = 6'h19; opa = 32'd3; opb = 32'd4;
    @(negedge clk);
    start = 1'b0;
    wait_idle(n);
    chk("R10 busy cycles", 32'(n + 3), 32'd32);
    chk("R10 hi remainder", hi_q, 32'd2);
    chk("R10 lo quotient", lo_q, 32'd14);
    @(negedge clk);
    chk("R10 no restart", 32'(busy), 32'h0);
  endtask

  task automatic t_read_busy;
    logic [63:0] e;
    int n;
    bit early;
    e = emul(1'b1, 32'hFFFF_FFFD, 32'd5);
    issue(6'h18, 32'hFFFF_FFFD, 32'd5);
    start = 1'b1; func = 6'h12;
    @(negedge clk);
    start = 1'b0;
    n = 1; early = 1'b0;
    while (!rd_valid && n < 100) begin
      if (rd_valid && busy) early = 1'b1;
      n++;
      @(negedge clk);
    end
    chk("R12 reply cycle", 32'(n), 32'd33);
    chk("R12 reply data", rd_data, e[31:0]);
    chk("R12 idle at reply", 32'(busy), 32'h0);
    chk("R12 not early", 32'(early), 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write();
    t_read_idle();
    t_unknown();
    t_arith("R3 ff*ff", 6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_arith("R3 mixed", 6'h19, 32'h1234_5678, 32'h9ABC_DEF0);
    t_arith("R3 zero", 6'h19, 32'h0, 32'hDEAD_BEEF);
    t_arith("R4 -1*5", 6'h18, 32'hFFFF_FFFF, 32'd5);
    t_arith("R4 min*min", 6'h18, 32'h8000_0000, 32'h8000_0000);
    t_arith("R4 -7*-3", 6'h18, 32'hFFFF_FFF9, 32'hFFFF_FFFD);
    t_arith("R4 max*-1", 6'h18, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    t_arith("R5 100/7", 6'h1B, 32'd100, 32'd7);
    t_arith("R5 big/3", 6'h1B, 32'hFFFF_FFFF, 32'd3);
    t_arith("R5 5/9", 6'h1B, 32'd5, 32'd9);
    t_arith("R6 -7/2", 6'h1A, 32'hFFFF_FFF9, 32'd2);
    t_arith("R6 7/-2", 6'h1A, 32'd7, 32'hFFFF_FFFE);
    t_arith("R6 -7/-2", 6'h1A, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    t_arith("R6 min/-1", 6'h1A, 32'h8000_0000, 32'hFFFF_FFFF);
    t_div_zero();
    t_ignore_busy();
    t_read_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule